// File: doc/BRIEF.md
# Line-21 Caption Waveform Serializer

This block produces the digital level sequence for a caption line that a video encoder adds into its luma path. On the caption line of field one (line 21) and the caption line of field two (line 284) it emits a fixed lead-in: seven cycles of clock run-in, then three start bits. Two 8-bit characters follow, sent NRZ with the least significant bit first. Each character holds 7 data bits taken from a register, and the hardware places an odd-parity bit in bit 7. The output is a 2-bit level code for each sample, which a later stage turns into an analog amplitude: idle (no caption), low (0 IRE), high (50 IRE) or run-in crest.

Software writes characters and field enables through a simple write port. A timing generator supplies a one-cycle horizontal sync strobe, the current line number and the field flag. When a caption line starts, the stored characters for that field move into a shift register and the stored copy is cleared. If software writes nothing before the next caption line of that field, null characters (0x80 after parity) go out. A per-field status flag shows whether fresh data is waiting. The bit period is one line divided by 32. A fractional accumulator running on the 13.5 MHz pixel clock generates it, so 858 clocks span 32 bits.

Top module: `cc21_serializer`

## Requirements
- R1: After reset, lvl_o is idle (0) and status_o is 0. The enable register resets to 2'b01, so only field one is enabled.
- R2: A caption line is sent only when hsync is high on line 21 with field=0 and enable bit 0 set, or on line 284 with field=1 and enable bit 1 set. In every other case lvl_o stays idle. Address 4 writes the enables from wr_data[1:0], with bit 0 for field one.
- R3: lvl_o stays idle for the first 142 clocks after the cycle that samples hsync. The first half-bit appears on the 142nd clock after that edge.
- R4: The run-in is 7 bit periods. In each one the first half is code 3 (crest) and the second half is code 1 (low).
- R5: The three start bits 0, 0, 1 follow the run-in as codes 1, 1, 2, each lasting one bit period.
- R6: Byte one goes out before byte two, each LSB first. Bits 0..6 come from the register, and bit 7 is the odd parity of those seven bits. Bit 7 of wr_data is ignored. Addresses 0/1 hold field-one bytes 1/2, and addresses 2/3 hold field-two bytes 1/2. A data 1 is code 2 and a data 0 is code 1.
- R7: Half-bit boundaries come from an accumulator that adds 64 every clock. Each time the sum reaches 858, it emits a half-bit and wraps. Half-bit n therefore covers clock offset floor((2n+1)·858/128) after the start.
- R8: Starting a field's caption line clears that field's stored bytes. The next line for that field sends null characters unless new data is written first.
- R9: A write to either byte of a field sets that field's status bit (status_o[0] for field one). The bit clears when that field's caption line starts.
- R10: A write made while a line is being sent does not change that line. The new data goes out on the next eligible line.
- R11: After 52 half-bits (26 bit periods) lvl_o returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0..3 character bytes, 4 field enables |
| wr_data | input | 8 | Write data |
| hsync | input | 1 | One-cycle line start strobe |
| line_num | input | 10 | Current line number |
| field | input | 1 | 0 = field one, 1 = field two |
| lvl_o | output | 2 | Level code: 0 idle, 1 low, 2 high, 3 run-in crest |
| status_o | output | 2 | Per-field flag: fresh data waiting |

## Verification
The bench samples each line at every half-bit centre and compares it with a waveform built from the requirements. It uses character pairs with all-ones, all-zeros, alternating bits and set bit 7, so parity inversion, bit order, byte order and the masking of bit 7 each show up as distinct mismatches. Lines on the wrong number or with the wrong field, and lines of a disabled field, must stay idle. This separates eligibility decoding from enable handling. Back-to-back lines with no write between them, and with a write in the middle of a line, show apart clear-after-send from the timing of a late update.

// File: rtl/cc21_pkg.sv
package cc21_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE  = 2'd0,
    LVL_LOW   = 2'd1,
    LVL_HIGH  = 2'd2,
    LVL_RUNIN = 2'd3
  } lvl_e;

  localparam int RUNIN_HALVES = 14;
  localparam int START_HALVES = 6;
  localparam int DATA_HALVES  = 32;
  localparam int TOTAL_HALVES = RUNIN_HALVES + START_HALVES + DATA_HALVES;

  function automatic logic [7:0] with_parity(input logic [6:0] d);
    return {~^d, d};
  endfunction
endpackage

// File: rtl/cc21_regs.sv
module cc21_regs (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [1:0]      load_f,
  output logic [1:0]      en,
  output logic [1:0][6:0] byte_a,
  output logic [1:0][6:0] byte_b,
  output logic [1:0]      stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 2'b01;
      byte_a <= '0;
      byte_b <= '0;
      stat   <= '0;
    end else begin
      for (int f = 0; f < 2; f++) begin
        if (load_f[f]) begin
          byte_a[f] <= '0;
          byte_b[f] <= '0;
          stat[f]   <= 1'b0;
        end
        if (wr_en && wr_addr == 3'(2*f)) begin
          byte_a[f] <= wr_data[6:0];
          stat[f]   <= 1'b1;
        end
        if (wr_en && wr_addr == 3'(2*f+1)) begin
          byte_b[f] <= wr_data[6:0];
          stat[f]   <= 1'b1;
        end
      end
      if (wr_en && wr_addr == 3'd4) en <= wr_data[1:0];
    end
  end

  // R9
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> stat[0]);

  // R8
  data_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_f[0] && !(wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1)))
      |=> (byte_a[0] == '0 && byte_b[0] == '0));
endmodule

// File: rtl/cc21_bitclk.sv
module cc21_bitclk #(
  parameter int LINE_CLKS     = 858,
  parameter int BITS_PER_LINE = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);
  localparam int STEP = 2 * BITS_PER_LINE;
  localparam int AW   = $clog2(LINE_CLKS + STEP + 1);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  always_comb begin
    sum       = acc + AW'(STEP);
    half_tick = run && (sum >= AW'(LINE_CLKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (!run)      acc <= '0;
    else if (half_tick) acc <= sum - AW'(LINE_CLKS);
    else                acc <= sum;
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);
endmodule

// File: rtl/cc21_seq.sv
module cc21_seq
  import cc21_pkg::*;
#(
  parameter int LEAD_CLKS = 142
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] chars,
  input  logic        half_tick,
  output logic        idle,
  output logic        run,
  output lvl_e        lvl
);
  localparam int DW = $clog2(LEAD_CLKS + 1);
  localparam int HW = $clog2(TOTAL_HALVES + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} st_e;

  st_e           state;
  logic [DW-1:0] dly;
  logic [HW-1:0] hi;
  logic [15:0]   shreg;

  assign idle = (state == S_IDLE);
  assign run  = (state == S_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      dly   <= '0;
      hi    <= '0;
      shreg <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_WAIT;
          shreg <= chars;
          dly   <= '0;
        end
        S_WAIT: begin
          if (dly == DW'(LEAD_CLKS - 1)) begin
            state <= S_SEND;
            hi    <= '0;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        S_SEND: if (half_tick) begin
          if (hi >= HW'(RUNIN_HALVES + START_HALVES) && hi[0])
            shreg <= shreg >> 1;
          if (hi == HW'(TOTAL_HALVES - 1)) state <= S_IDLE;
          else                             hi    <= hi + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    lvl = LVL_IDLE;
    if (state == S_SEND) begin
      if (hi < HW'(RUNIN_HALVES))
        lvl = hi[0] ? LVL_LOW : LVL_RUNIN;
      else if (hi < HW'(RUNIN_HALVES + START_HALVES))
        lvl = (hi >= HW'(RUNIN_HALVES + START_HALVES - 2)) ? LVL_HIGH : LVL_LOW;
      else
        lvl = shreg[0] ? LVL_HIGH : LVL_LOW;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> (state == S_IDLE));
endmodule

// File: rtl/cc21_serializer.sv
module cc21_serializer
  import cc21_pkg::*;
#(
  parameter int LINE_CLKS     = 858,
  parameter int BITS_PER_LINE = 32,
  parameter int LEAD_CLKS     = 142,
  parameter int LINE_W        = 10,
  parameter int LINE_F1       = 21,
  parameter int LINE_F2       = 284
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hsync,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  output logic [1:0]        lvl_o,
  output logic [1:0]        status_o
);
  logic [1:0]      en;
  logic [1:0][6:0] byte_a;
  logic [1:0][6:0] byte_b;
  logic [1:0]      elig;
  logic [1:0]      load_f;
  logic            seq_idle;
  logic            seq_run;
  logic            half_tick;
  logic [15:0]     chars;
  lvl_e            lvl;

  always_comb begin
    elig[0] = hsync && !field && line_num == LINE_W'(LINE_F1) && en[0];
    elig[1] = hsync &&  field && line_num == LINE_W'(LINE_F2) && en[1];
    load_f  = elig & {2{seq_idle}};
    if (elig[1]) chars = {with_parity(byte_b[1]), with_parity(byte_a[1])};
    else         chars = {with_parity(byte_b[0]), with_parity(byte_a[0])};
  end

  cc21_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_f(load_f), .en(en), .byte_a(byte_a),
    .byte_b(byte_b), .stat(status_o)
  );

  cc21_bitclk #(.LINE_CLKS(LINE_CLKS), .BITS_PER_LINE(BITS_PER_LINE)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(seq_run), .half_tick(half_tick)
  );

  cc21_seq #(.LEAD_CLKS(LEAD_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(|load_f), .chars(chars),
    .half_tick(half_tick), .idle(seq_idle), .run(seq_run), .lvl(lvl)
  );

  assign lvl_o = lvl;

  // R4
  runin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_run) |-> (lvl_o == 2'd3));
endmodule

// File: tb/test_cc21_serializer.sv
module test_cc21_serializer;
  localparam int LEAD = 142;
  localparam int LCLK = 858;
  localparam int CAP  = LEAD + 720;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       hsync = 1'b0;
  logic [9:0] line_num = '0;
  logic       field = 1'b0;
  logic [1:0] lvl_o;
  logic [1:0] status_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [1:0] cap [CAP];

  // entries: {field, byte1, byte2}
  localparam logic [16:0] VEC [4] = '{
    {1'b0, 8'h41, 8'h42},
    {1'b1, 8'h7F, 8'h00},
    {1'b0, 8'h55, 8'h2A},
    {1'b1, 8'h13, 8'hE6}
  };

  cc21_serializer i_cc21_serializer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .line_num(line_num), .field(field),
    .lvl_o(lvl_o), .status_o(status_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_line(input int ln, input bit f);
    @(negedge clk); line_num = 10'(ln); field = f; hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
    for (int c = 0; c < CAP; c++) begin
      cap[c] = lvl_o;
      @(negedge clk);
    end
  endtask

  function automatic logic [1:0] exp_hb(input int n, input logic [7:0] b1,
                                       input logic [7:0] b2);
    logic [15:0] w;
    w = {~^b2[6:0], b2[6:0], ~^b1[6:0], b1[6:0]};
    if (n < 14) return (n % 2) ? 2'd1 : 2'd3;
    if (n < 20) return (n >= 18) ? 2'd2 : 2'd1;
    return w[(n - 20) / 2] ? 2'd2 : 2'd1;
  endfunction

  // R3 R4 R5 R6 R7 R11: whole-line compare at half-bit centres
  task automatic check_line(input string req, input logic [7:0] b1,
                            input logic [7:0] b2);
    int bad = -1;
    int act = 0;
    int exp = 0;
    if (cap[LEAD-1] != 2'd0) begin bad = LEAD - 1; act = cap[LEAD-1]; exp = 0; end
    for (int n = 0; n < 52 && bad < 0; n++) begin
      int c = LEAD + ((2*n + 1) * LCLK) / 128;
      if (cap[c] != exp_hb(n, b1, b2)) begin
        bad = c; act = cap[c]; exp = exp_hb(n, b1, b2);
      end
    end
    if (bad < 0 && cap[LEAD+715] != 2'd0) begin bad = LEAD + 715; act = cap[LEAD+715]; exp = 0; end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s at offset %0d actual=%0d expected=%0d", req, bad, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    int bad = -1;
    for (int c = 0; c < CAP; c++) if (bad < 0 && cap[c] != 2'd0) bad = c;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s at offset %0d actual=%0d expected=0", req, bad, cap[bad]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lvl after reset", lvl_o, 0);
    check("R1 status after reset", status_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 default enables: field two disabled, field one sends nulls
    run_line(284, 1'b1);
    check_idle("R2 field two disabled by default");
    run_line(21, 1'b0);
    check_line("R1 field one enabled by default", 8'h00, 8'h00);

    // R2 wrong line / wrong field
    wr(3'd0, 8'h41); wr(3'd1, 8'h42);
    run_line(22, 1'b0);
    check_idle("R2 wrong line number");
    run_line(21, 1'b1);
    check_idle("R2 field mismatch");
    check("R9 status held while not sent", status_o, 1);

    // table walk with both fields enabled
    wr(3'd4, 8'h03);
    foreach (VEC[i]) begin
      logic f;
      logic [7:0] b1, b2;
      {f, b1, b2} = VEC[i];
      wr(f ? 3'd2 : 3'd0, b1);
      wr(f ? 3'd3 : 3'd1, b2);
      check("R9 status set by write", status_o[f], 1);
      run_line(f ? 284 : 21, f);
      check_line("R6 characters and parity", b1, b2);
      check("R9 status cleared by send", status_o[f], 0);
    end

    // R8 nulls after consumption
    run_line(21, 1'b0);
    check_line("R8 null after clear", 8'h00, 8'h00);

    // R10 write mid-transmission
    wr(3'd0, 8'h11); wr(3'd1, 8'h22);
    fork
      run_line(21, 1'b0);
      begin
        repeat (300) @(negedge clk);
        wr(3'd0, 8'h33); wr(3'd1, 8'h44);
      end
    join
    check_line("R10 current line unchanged", 8'h11, 8'h22);
    check("R10 status set by late write", status_o[0], 1);
    run_line(21, 1'b0);
    check_line("R10 late data on next line", 8'h33, 8'h44);

    // R2 disable field one via enable register
    wr(3'd4, 8'h02);
    wr(3'd0, 8'h7E);
    run_line(21, 1'b0);
    check_idle("R2 field one disabled");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule